// File: doc/BRIEF.md
# Synthesizer Divider Configuration Interface

This block keeps the programming state of a frequency synthesizer: a feedback divider value, an output divider code and a two-bit test selector. It drives the divider values to the analog side and drives a single test pin. The configuration can come from two places. The first is a set of level pins, which the block either follows or captures on a strobe. The second is a serial port made of a data line, a shift clock and a transfer strobe.

Every control and data pin is sampled in one system clock domain through a short synchronizer chain. Strobe edges are found by comparing each synchronized level with its value one clock earlier. While synchronous reset is high, the block loads the divider values straight from the level pins. Pins strapped on the board therefore set the configuration at power-up.

Top module: `fsyn_cfg_if`

## Requirements
- R1: While `rst` is high, `fb_div_val` and `od_code` load from `fb_pins` and `od_pins`, the test selector clears to 00, and `test_out` is 0.
- R2: While `par_latch` is low (parallel mode), `fb_div_val` and `od_code` follow the level pins, with a latency of SYNC_DEPTH+1 clocks.
- R3: On a rising edge of `par_latch`, the pin values are captured. They then stay fixed while the pins change, until `par_latch` falls or a serial transfer occurs.
- R4: A rising edge of `ser_clk` shifts `ser_din` into a 14-bit register, but only while `par_latch` is high. Rising edges of `ser_clk` while `par_latch` is low are ignored. The first bit sent ends in bit 13. The fields are: bits 13:12 test selector, bits 11:9 output divider code, bits 8:0 feedback divider value, with the feedback value's LSB sent last.
- R5: A rising edge of `ser_xfer` while `par_latch` is high copies the shift register into the configuration. A falling edge of `ser_xfer` keeps that value, and later shifts with `ser_xfer` low leave the outputs unchanged.
- R6: While `ser_xfer` is high in serial mode, every accepted shift also updates the configuration with the new register contents.
- R7: A serial transfer replaces a value captured from the parallel pins. The test selector changes only through serial transfers, so parallel loads leave it as it was.
- R8: In serial mode `test_out` depends on the selector. 00 gives 0. 01 gives the synchronized `ser_din`. 10 gives the synchronized `fb_tick`. 11 (reserved) gives 0.
- R9: While `par_latch` is low, `test_out` is 0 whatever the selector holds.
- R10: `div_rst` leaves the divider values and the selector unchanged. With selector 10 it forces `test_out` to 0, because the divider it observes is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous power-up reset, active high |
| par_latch | input | 1 | Low: follow pins; rising edge: capture pins; high: serial mode |
| ser_xfer | input | 1 | Serial transfer strobe |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_din | input | 1 | Serial data |
| fb_pins | input | M_W (9) | Feedback divider value pins |
| od_pins | input | N_W (3) | Output divider code pins |
| div_rst | input | 1 | Divider reset (does not touch configuration) |
| fb_tick | input | 1 | Feedback divider output, observed on the test pin |
| fb_div_val | output | M_W (9) | Active feedback divider value |
| od_code | output | N_W (3) | Active output divider code |
| test_out | output | 1 | Test pin |

## Verification
The hardest state to reach is a selector that can only be seen through `test_out`. The selector can only be written by a full 14-bit serial frame. The stimulus sends each of the four selector codes as a complete frame and then toggles `ser_din`, `fb_tick` and `div_rst` to see which signal reaches the pin. Two other orderings are driven on purpose, with random frames and pin loads mixed in between. In one, shift-clock edges arrive during parallel mode and must be dropped. In the other, a serial transfer replaces a parallel capture.

// File: rtl/fsyn_cfg_pkg.sv
package fsyn_cfg_pkg;
   // test pin source selected by the two top frame bits
   typedef enum logic [1:0] {
      TSEL_LOW   = 2'b00,
      TSEL_SERIN = 2'b01,
      TSEL_FBDIV = 2'b10,
      TSEL_RSVD  = 2'b11
   } tsel_e;
   localparam int TSEL_W = 2;
endpackage

// File: rtl/fsyn_cfg_sync.sv
module fsyn_cfg_sync #(
   parameter int W = 1,
   parameter int DEPTH = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("fsyn_cfg_sync: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk) begin
         if (rst) stg <= RST_VAL;
         else     stg <= d;
      end
      assign q = stg;
   end else begin : g_chain
      logic [DEPTH-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
         if (rst) stg <= {DEPTH{RST_VAL}};
         else     stg <= {stg[DEPTH-2:0], d};
      end
      assign q = stg[DEPTH-1];
   end
endmodule

// File: rtl/fsyn_frame_shift.sv
module fsyn_frame_shift #(
   parameter int FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               din,
   output logic [FRAME_W-1:0] cur,
   output logic [FRAME_W-1:0] nxt
);
   if (FRAME_W < 2) begin : g_bad_w
      $error("fsyn_frame_shift: FRAME_W must be at least 2");
   end

   // first bit in ends at the MSB after a whole frame
   assign nxt = en ? {cur[FRAME_W-2:0], din} : cur;

   always_ff @(posedge clk) begin
      if (rst) cur <= '0;
      else     cur <= nxt;
   end
endmodule

// File: rtl/fsyn_test_mux.sv
module fsyn_test_mux
   import fsyn_cfg_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  serial_mode,
   input  tsel_e sel,
   input  logic  ser_din,
   input  logic  fb_tick,
   input  logic  div_rst,
   output logic  test_out
);
   logic pick;

   always_comb begin
      unique case (sel)
         TSEL_SERIN: pick = ser_din;
         TSEL_FBDIV: pick = fb_tick & ~div_rst;
         default:    pick = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) test_out <= 1'b0;
      else     test_out <= serial_mode & pick;
   end
endmodule

// File: rtl/fsyn_cfg_if.sv
module fsyn_cfg_if
   import fsyn_cfg_pkg::*;
#(
   parameter int M_W = 9,
   parameter int N_W = 3,
   parameter int SYNC_DEPTH = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           par_latch,
   input  logic           ser_xfer,
   input  logic           ser_clk,
   input  logic           ser_din,
   input  logic [M_W-1:0] fb_pins,
   input  logic [N_W-1:0] od_pins,
   input  logic           div_rst,
   input  logic           fb_tick,
   output logic [M_W-1:0] fb_div_val,
   output logic [N_W-1:0] od_code,
   output logic           test_out
);
   localparam int FRAME_W = TSEL_W + N_W + M_W;
   localparam int CTL_W   = 3;
   localparam int DAT_W   = M_W + N_W + 3;
   // control order {par_latch, ser_xfer, ser_clk}; par_latch idles high
   localparam logic [CTL_W-1:0] CTL_RST = 3'b100;

   if (M_W < 1 || N_W < 1) begin : g_bad_w
      $error("fsyn_cfg_if: divider widths must be positive");
   end

   logic [CTL_W-1:0] ctl_s, ctl_prev;
   logic [DAT_W-1:0] dat_s;

   fsyn_cfg_sync #(.W(CTL_W), .DEPTH(SYNC_DEPTH), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk(clk), .rst(rst), .d({par_latch, ser_xfer, ser_clk}), .q(ctl_s));

   fsyn_cfg_sync #(.W(DAT_W), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_dat_sync (
      .clk(clk), .rst(rst), .d({fb_pins, od_pins, ser_din, fb_tick, div_rst}), .q(dat_s));

   always_ff @(posedge clk) begin
      if (rst) ctl_prev <= CTL_RST;
      else     ctl_prev <= ctl_s;
   end

   logic par_lvl, par_rise, xfer_lvl, xfer_rise, sclk_rise;
   logic [M_W-1:0] fb_s;
   logic [N_W-1:0] od_s;
   logic din_s, tick_s, drst_s;

   assign par_lvl   = ctl_s[2];
   assign par_rise  = ctl_s[2] & ~ctl_prev[2];
   assign xfer_lvl  = ctl_s[1];
   assign xfer_rise = ctl_s[1] & ~ctl_prev[1];
   assign sclk_rise = ctl_s[0] & ~ctl_prev[0];
   assign {fb_s, od_s, din_s, tick_s, drst_s} = dat_s;

   logic [FRAME_W-1:0] sh_cur, sh_nxt;

   fsyn_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst(rst), .en(par_lvl & sclk_rise), .din(din_s),
      .cur(sh_cur), .nxt(sh_nxt));

   logic [TSEL_W-1:0] t_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         fb_div_val <= fb_pins;
         od_code    <= od_pins;
         t_q        <= '0;
      end else if (!par_lvl || par_rise) begin
         fb_div_val <= fb_s;
         od_code    <= od_s;
      end else if (xfer_lvl && (xfer_rise || sclk_rise)) begin
         {t_q, od_code, fb_div_val} <= sh_nxt;
      end
   end

   fsyn_test_mux u_tmux (
      .clk(clk), .rst(rst), .serial_mode(par_lvl), .sel(tsel_e'(t_q)),
      .ser_din(din_s), .fb_tick(tick_s), .div_rst(drst_s), .test_out(test_out));
endmodule

// File: rtl/fsyn_cfg_chk.sv
module fsyn_cfg_chk #(
   parameter int M_W = 9,
   parameter int N_W = 3,
   parameter int SYNC_DEPTH = 2
) (
   input logic           clk,
   input logic           rst,
   input logic           par_latch,
   input logic           ser_xfer,
   input logic [M_W-1:0] fb_pins,
   input logic [M_W-1:0] fb_div_val,
   input logic [N_W-1:0] od_code,
   input logic           test_out,
   input logic [1:0]     tsel
);
   logic [2:0] age;
   always_ff @(posedge clk) begin
      if (rst)              age <= '0;
      else if (age != 3'd7) age <= age + 3'd1;
   end

   // reserved selector keeps the test pin low (R8)
   p_rsvd_low_r8: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd1 && $past(tsel) == 2'b11) |-> !test_out);

   // selector 00 keeps the test pin low (R8)
   p_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd1 && $past(tsel) == 2'b00) |-> !test_out);

   if (SYNC_DEPTH == 2) begin : g_lat3
      // parallel mode is transparent with three clocks of latency (R2)
      p_par_follow_r2: assert property (@(posedge clk) disable iff (rst)
         (age >= 3'd4 && !$past(par_latch, 3)) |-> fb_div_val == $past(fb_pins, 3));

      // test pin low in parallel mode (R9)
      p_par_test_low_r9: assert property (@(posedge clk) disable iff (rst)
         (age >= 3'd4 && !$past(par_latch, 3)) |-> !test_out);

      // no parallel edge and no transfer strobe: values held (R3)
      p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
         (age >= 3'd5 && $past(par_latch, 3) && $past(par_latch, 4) && !$past(ser_xfer, 3))
         |-> ($stable(fb_div_val) && $stable(od_code)));
   end
endmodule

bind fsyn_cfg_if fsyn_cfg_chk #(.M_W(M_W), .N_W(N_W), .SYNC_DEPTH(SYNC_DEPTH)) u_chk (
   .clk(clk), .rst(rst), .par_latch(par_latch), .ser_xfer(ser_xfer),
   .fb_pins(fb_pins), .fb_div_val(fb_div_val), .od_code(od_code),
   .test_out(test_out), .tsel(t_q));

// File: tb/fsyn_cfg_if_test.sv
module fsyn_cfg_if_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst, par_latch, ser_xfer, ser_clk, ser_din, div_rst, fb_tick;
   logic [8:0] fb_pins;
   logic [2:0] od_pins;
   logic [8:0] fb_div_val;
   logic [2:0] od_code;
   logic test_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [13:0] sh;
   logic [8:0]  em;
   logic [2:0]  en;
   logic [1:0]  et;

   always #(CLK_PERIOD/2) clk = ~clk;

   fsyn_cfg_if uut (
      .clk(clk), .rst(rst), .par_latch(par_latch), .ser_xfer(ser_xfer),
      .ser_clk(ser_clk), .ser_din(ser_din), .fb_pins(fb_pins), .od_pins(od_pins),
      .div_rst(div_rst), .fb_tick(fb_tick), .fb_div_val(fb_div_val),
      .od_code(od_code), .test_out(test_out));

   function automatic logic exp_test(logic pl, logic [1:0] t, logic d, logic f, logic r);
      if (!pl) return 1'b0;
      case (t)
         2'b01:   return d;
         2'b10:   return f & ~r;
         default: return 1'b0;
      endcase
   endfunction

   task automatic step();
      repeat (4) @(negedge clk);
   endtask

   task automatic chk_cfg(string req);
      checks++;
      if (fb_div_val !== em || od_code !== en) begin
         errors++;
         $display("FAIL %s: cfg got m=%0d n=%0d expected m=%0d n=%0d",
                  req, fb_div_val, od_code, em, en);
      end
   endtask

   task automatic chk_test(string req);
      logic e;
      e = exp_test(par_latch, et, ser_din, fb_tick, div_rst);
      checks++;
      if (test_out !== e) begin
         errors++;
         $display("FAIL %s: test_out got %b expected %b", req, test_out, e);
      end
   endtask

   task automatic do_shift(logic b, string req);
      ser_din = b;
      step();
      ser_clk = 1'b1;
      step();
      if (par_latch) begin
         sh = {sh[12:0], b};
         if (ser_xfer) {et, en, em} = sh;
      end else begin
         em = fb_pins; en = od_pins;
      end
      chk_cfg(req);
      ser_clk = 1'b0;
      step();
   endtask

   task automatic send_frame(logic [1:0] t, logic [2:0] n, logic [8:0] m, string req);
      logic [13:0] f;
      f = {t, n, m};
      for (int i = 13; i >= 0; i--) do_shift(f[i], req);
   endtask

   task automatic xfer_pulse(string req);
      ser_xfer = 1'b1;
      step();
      if (par_latch) {et, en, em} = sh;
      chk_cfg(req);
      ser_xfer = 1'b0;
      step();
      chk_cfg(req);
   endtask

   task automatic par_load(logic [8:0] m, logic [2:0] n);
      par_latch = 1'b0; fb_pins = m; od_pins = n;
      step();
      em = m; en = n;
      chk_cfg("R2");
      par_latch = 1'b1;
      step();
      fb_pins = 9'($urandom); od_pins = 3'($urandom);
      step();
      chk_cfg("R3");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1bad5eed));
      rst = 1'b1; par_latch = 1'b1; ser_xfer = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
      div_rst = 1'b0; fb_tick = 1'b0; fb_pins = 9'd500; od_pins = 3'd3;
      sh = '0; et = 2'b00;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      em = 9'd500; en = 3'd3;
      chk_cfg("R1 strap load");
      chk_test("R1 test low");

      // pins move while latched: no effect
      fb_pins = 9'd257; od_pins = 3'd6;
      step();
      chk_cfg("R3 held after reset");

      // parallel transparency
      par_latch = 1'b0;
      step();
      em = 9'd257; en = 3'd6;
      chk_cfg("R2 follow");
      fb_pins = 9'd311; od_pins = 3'd1;
      step();
      em = 9'd311; en = 3'd1;
      chk_cfg("R2 follow again");
      chk_test("R9 parallel low");
      par_latch = 1'b1;
      step();
      fb_pins = 9'd0; od_pins = 3'd7;
      step();
      chk_cfg("R3 capture");

      // serial frame, selector 01
      send_frame(2'b01, 3'd5, 9'd300, "R4 shift no xfer");
      xfer_pulse("R5 transfer");
      checks++;
      if (em !== 9'd300 || en !== 3'd5 || et !== 2'b01) begin
         errors++;
         $display("FAIL R4 frame order: model m=%0d n=%0d t=%0d expected 300 5 1", em, en, et);
      end
      ser_din = 1'b1; step(); chk_test("R8 serin 1");
      ser_din = 1'b0; step(); chk_test("R8 serin 0");
      do_shift(1'b1, "R5 hold after fall");
      do_shift(1'b0, "R5 hold after fall");

      // selector 10 and divider reset
      send_frame(2'b10, 3'd2, 9'd499, "R4");
      xfer_pulse("R5");
      fb_tick = 1'b1; step(); chk_test("R8 fb 1");
      fb_tick = 1'b0; step(); chk_test("R8 fb 0");
      div_rst = 1'b1; fb_tick = 1'b1; step();
      chk_test("R10 test low in reset");
      chk_cfg("R10 cfg unchanged");
      div_rst = 1'b0; step();
      chk_test("R10 released");
      chk_cfg("R10 cfg unchanged after");

      // reserved selector
      send_frame(2'b11, 3'd4, 9'd250, "R4");
      xfer_pulse("R5");
      ser_din = 1'b1; fb_tick = 1'b1; step();
      chk_test("R8 reserved low");
      fb_tick = 1'b0;

      // selector 01, then parallel mode: test low, selector kept
      send_frame(2'b01, 3'd0, 9'd256, "R4");
      xfer_pulse("R5");
      par_latch = 1'b0; ser_din = 1'b1; fb_pins = 9'd444; od_pins = 3'd2;
      step();
      em = 9'd444; en = 3'd2;
      chk_cfg("R2");
      chk_test("R9 test low sel 01");
      // shift clock edges in parallel mode are dropped
      do_shift(1'b1, "R4 ignored in parallel");
      do_shift(1'b0, "R4 ignored in parallel");
      par_latch = 1'b1; ser_din = 1'b1;
      step();
      chk_test("R7 selector kept");
      // serial transfer replaces the captured pins
      xfer_pulse("R7 override");

      // transparent serial
      ser_xfer = 1'b1;
      step();
      {et, en, em} = sh;
      chk_cfg("R6 entry");
      for (int i = 0; i < 5; i++) do_shift(1'($urandom), "R6 transparent");
      ser_xfer = 1'b0;
      step();
      do_shift(1'b1, "R5 hold");

      // random mix
      for (int it = 0; it < 60; it++) begin
         int op;
         op = $urandom_range(0, 3);
         case (op)
            0: par_load(9'($urandom), 3'($urandom));
            1: begin
               send_frame(2'($urandom), 3'($urandom), 9'($urandom), "R4");
               xfer_pulse("R5");
            end
            2: begin
               ser_xfer = 1'b1; step();
               {et, en, em} = sh;
               chk_cfg("R6");
               for (int k = 0; k < 3; k++) do_shift(1'($urandom), "R6");
               ser_xfer = 1'b0; step();
            end
            default: begin
               ser_din = 1'($urandom); fb_tick = 1'($urandom); div_rst = 1'($urandom);
               step();
               chk_test("R8");
               chk_cfg("R10");
               div_rst = 1'b0;
            end
         endcase
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule